// File: doc/BRIEF.md
# NAND Ready/Busy Completion Monitor

This block works out when a NAND flash operation on a single x8 device has finished. An operation is a page load, a page program or a block erase. The sequencer that issues the command to the device pulses `op_start` with the operation kind. The monitor then reports completion with a one-cycle `done` pulse and a sticky interrupt flag.

There are two ways to detect completion, and a mode bit chooses between them. In pin mode the monitor passes the device's ready/busy line through a synchronizer and finishes on its low-to-high transition. In polling mode it first waits a programmable number of cycles, with a separate count for each operation kind. It then asks the external command sequencer for a status read and checks the returned status byte. If the device is still busy, it waits a programmable gap and asks again.

A write to the mode bit is deferred while an operation is outstanding, so the detection method can never change in the middle of an operation. Command and address sequencing, the data path, ECC and the host bus are not part of this block.

Top module: `nand_rdy_monitor`

## Requirements
- R1: After reset `done`, `fail`, `irq`, `busy` and `stat_req` are 0, and `poll_mode` is 0 (pin mode).
- R2: In pin mode, when `rb_in` rises while an operation is outstanding, `done` is high in the third clock cycle after the rise. This allows two synchronizer flops and one output register. `fail` is 0 for a pin-mode completion.
- R3: In pin mode, an `rb_in` that stays high, or stays low, never completes an operation, and `stat_req` is never raised.
- R4: `op_kind` encoding: 0 = page load, 1 = program, 2 = erase. In polling mode, a load started at clock edge k raises `stat_req` after edge k+1+L, where L is `cfg_load_wait`.
- R5: In polling mode, a program operation uses `cfg_prog_wait` in place of L.
- R6: In polling mode, an erase operation uses `cfg_erase_wait` in place of L.
- R7: `stat_req` stays high with `stat_cmd` = 0x70 until `stat_valid` is seen. If status bit 6 of that response is 0, `stat_req` drops and rises again after edge e+1+G. Here e is the response edge and G is `cfg_poll_gap`.
- R8: A response with status bit 6 = 1 finishes the operation: `done` is high in the next cycle, `stat_req` drops, and `fail` equals status bit 0.
- R9: A wait count or gap of zero raises `stat_req` in the cycle right after the start edge or the response edge.
- R10: Every completion sets `irq`. `irq` then stays set until an `irq_clr` edge with no completion on that same edge. A completion on the same edge as `irq_clr` leaves `irq` set.
- R11: A mode write while idle takes effect on that edge. A mode write while busy leaves `poll_mode` unchanged until the cycle after completion.
- R12: `done` is a single-cycle pulse, and `op_start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode_wr | input | 1 | Strobe that writes the mode bit |
| cfg_mode_poll | input | 1 | Mode value to write: 1 = polling, 0 = pin |
| cfg_load_wait | input | 16 | Wait before the first poll of a page load |
| cfg_prog_wait | input | 16 | Wait before the first poll of a program |
| cfg_erase_wait | input | 16 | Wait before the first poll of an erase |
| cfg_poll_gap | input | 16 | Wait between successive polls |
| op_start | input | 1 | Operation-start strobe |
| op_kind | input | 2 | Operation kind (0 load, 1 program, 2 erase) |
| rb_in | input | 1 | Asynchronous ready/busy line from the device, low = busy |
| stat_req | output | 1 | Request to the sequencer for a status read |
| stat_cmd | output | 8 | Command byte to use for the status read |
| stat_valid | input | 1 | Status byte is valid this cycle |
| stat_data | input | 8 | Status byte returned by the device |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Fail bit of the last completion |
| irq | output | 1 | Sticky completion interrupt |
| irq_clr | input | 1 | Write-one-to-clear for `irq` |
| busy | output | 1 | An operation is outstanding |
| poll_mode | output | 1 | Mode in effect: 1 = polling |

## Verification
The pin-mode patterns compare a ready line that stays high, one that stays low, and a real low-to-high edge; only the edge may finish the operation, and it must do so on the exact cycle. Polling is run once for each operation kind with different wait counts, so that choosing the wrong count shows up as a shifted request cycle. The status responses cover not-ready, ready with pass, and ready with fail, which separate the repeat-poll path from the finish path and check the fail bit. Other runs cover zero counts, a start pulse while busy, a mode write while busy, and a clear on the same edge as a completion; these probe the boundaries and priorities.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
   typedef enum logic [1:0] {
      OPK_LOAD  = 2'd0,
      OPK_PROG  = 2'd1,
      OPK_ERASE = 2'd2,
      OPK_RSVD  = 2'd3
   } op_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PIN,
      ST_WAIT,
      ST_REQ
   } mon_state_t;
endpackage

// File: rtl/nrm_sync.sv
module nrm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nrm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign sync_out = chain_q[STAGES-1];
   assign rise     = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/nrm_timer.sv
module nrm_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             expired
);
   if (CNT_W < 1) begin : g_bad_w
      $error("nrm_timer: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_rdy_monitor.sv
module nand_rdy_monitor
   import nrm_pkg::*;
#(
   parameter int         CNT_W       = 16,
   parameter int         SYNC_STAGES = 2,
   parameter int         RDY_BIT     = 6,
   parameter int         FAIL_BIT    = 0,
   parameter logic [7:0] CMD_STATUS  = 8'h70,
   parameter logic       POLL_RESET  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_mode_wr,
   input  logic             cfg_mode_poll,
   input  logic [CNT_W-1:0] cfg_load_wait,
   input  logic [CNT_W-1:0] cfg_prog_wait,
   input  logic [CNT_W-1:0] cfg_erase_wait,
   input  logic [CNT_W-1:0] cfg_poll_gap,
   input  logic             op_start,
   input  logic [1:0]       op_kind,
   input  logic             rb_in,
   output logic             stat_req,
   output logic [7:0]       stat_cmd,
   input  logic             stat_valid,
   input  logic [7:0]       stat_data,
   output logic             done,
   output logic             fail,
   output logic             irq,
   input  logic             irq_clr,
   output logic             busy,
   output logic             poll_mode
);
   localparam int STAT_W = 8;

   if (RDY_BIT < 0 || RDY_BIT >= STAT_W) begin : g_bad_rdy
      $error("nand_rdy_monitor: RDY_BIT outside status byte");
   end
   if (FAIL_BIT < 0 || FAIL_BIT >= STAT_W || FAIL_BIT == RDY_BIT) begin : g_bad_fail
      $error("nand_rdy_monitor: FAIL_BIT invalid");
   end

   mon_state_t       st_q;
   logic             mode_q, pend_q, pend_val_q;
   logic             done_q, fail_q, irq_q;
   logic             rb_sync, rb_rise;
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val, kind_wait;
   logic             resp_take, fin_pin, fin_poll, complete;
   logic             unused_stat;

   nrm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(rb_in),
      .sync_out(rb_sync), .rise(rb_rise)
   );

   always_comb begin
      unique case (op_kind_t'(op_kind))
         OPK_LOAD: kind_wait = cfg_load_wait;
         OPK_PROG: kind_wait = cfg_prog_wait;
         default:  kind_wait = cfg_erase_wait;
      endcase
   end

   assign resp_take = (st_q == ST_REQ) && stat_valid;
   assign fin_pin   = (st_q == ST_PIN) && rb_rise;
   assign fin_poll  = resp_take && stat_data[RDY_BIT];
   assign complete  = fin_pin || fin_poll;
   assign tmr_load  = ((st_q == ST_IDLE) && op_start && mode_q) ||
                      (resp_take && !stat_data[RDY_BIT]);
   assign tmr_val   = (st_q == ST_IDLE) ? kind_wait : cfg_poll_gap;
   assign unused_stat = ^{stat_data, rb_sync};

   nrm_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .run(st_q == ST_WAIT), .expired(tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (op_start) st_q <= mode_q ? ST_WAIT : ST_PIN;
            ST_PIN:  if (rb_rise) st_q <= ST_IDLE;
            ST_WAIT: if (tmr_expired) st_q <= ST_REQ;
            ST_REQ:  if (stat_valid) st_q <= stat_data[RDY_BIT] ? ST_IDLE : ST_WAIT;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= POLL_RESET;
         pend_q     <= 1'b0;
         pend_val_q <= POLL_RESET;
      end else if (st_q == ST_IDLE) begin
         if (cfg_mode_wr)  mode_q <= cfg_mode_poll;
         else if (pend_q)  mode_q <= pend_val_q;
         pend_q <= 1'b0;
      end else if (cfg_mode_wr) begin
         pend_q     <= 1'b1;
         pend_val_q <= cfg_mode_poll;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         fail_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         done_q <= complete;
         if (complete) fail_q <= fin_poll && stat_data[FAIL_BIT];
         if (complete)     irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
      end
   end

   assign stat_req  = (st_q == ST_REQ);
   assign stat_cmd  = CMD_STATUS;
   assign done      = done_q;
   assign fail      = fail_q;
   assign irq       = irq_q;
   assign busy      = (st_q != ST_IDLE);
   assign poll_mode = mode_q;
endmodule

// File: rtl/nrm_checker.sv
module nrm_checker (
   input logic clk,
   input logic rst_n,
   input logic done,
   input logic irq,
   input logic irq_clr,
   input logic busy,
   input logic poll_mode,
   input logic stat_req
);
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   assert_irq_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> irq);

   assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(poll_mode));

   assert_req_only_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_req |-> (poll_mode && busy));
endmodule

bind nand_rdy_monitor nrm_checker u_nrm_checker (
   .clk(clk), .rst_n(rst_n), .done(done), .irq(irq), .irq_clr(irq_clr),
   .busy(busy), .poll_mode(poll_mode), .stat_req(stat_req)
);

// File: tb/tb_nand_rdy_monitor.sv
module tb_nand_rdy_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mode_wr = 1'b0, cfg_mode_poll = 1'b0;
   logic [15:0] cfg_load_wait = 16'd5, cfg_prog_wait = 16'd9;
   logic [15:0] cfg_erase_wait = 16'd13, cfg_poll_gap = 16'd3;
   logic        op_start = 1'b0;
   logic [1:0]  op_kind = 2'd0;
   logic        rb_in = 1'b1;
   logic        stat_req;
   logic [7:0]  stat_cmd;
   logic        stat_valid = 1'b0;
   logic [7:0]  stat_data = 8'h00;
   logic        done, fail, irq, busy, poll_mode;
   logic        irq_clr = 1'b0;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;
   bit exp_q[$];

   always #10 clk = ~clk;

   nand_rdy_monitor dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode_wr(cfg_mode_wr), .cfg_mode_poll(cfg_mode_poll),
      .cfg_load_wait(cfg_load_wait), .cfg_prog_wait(cfg_prog_wait),
      .cfg_erase_wait(cfg_erase_wait), .cfg_poll_gap(cfg_poll_gap),
      .op_start(op_start), .op_kind(op_kind), .rb_in(rb_in),
      .stat_req(stat_req), .stat_cmd(stat_cmd), .stat_valid(stat_valid),
      .stat_data(stat_data), .done(done), .fail(fail), .irq(irq),
      .irq_clr(irq_clr), .busy(busy), .poll_mode(poll_mode)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic start_op(input logic [1:0] kind);
      op_start = 1'b1; op_kind = kind;
      tick();
      op_start = 1'b0;
   endtask

   task automatic expect_req_after(input int n, input string req);
      check(stat_req == 1'b0, req, "stat_req early", stat_req, 0);
      for (int i = 0; i < n; i++) begin
         tick();
         check(stat_req == 1'b0, req, "stat_req during wait", stat_req, 0);
      end
      tick();
      check(stat_req == 1'b1, req, "stat_req on time", stat_req, 1);
      check(stat_cmd == 8'h70, "R7", "stat_cmd", stat_cmd, 8'h70);
   endtask

   task automatic respond(input logic [7:0] data, input logic clr, input string req);
      if (data[6]) exp_q.push_back(data[0]);
      stat_valid = 1'b1; stat_data = data; irq_clr = clr;
      tick();
      stat_valid = 1'b0; irq_clr = 1'b0;
      check(done == data[6], req, "done after response", done, data[6]);
      check(stat_req == 1'b0, req, "stat_req dropped", stat_req, 0);
   endtask

   task automatic write_mode(input logic val);
      cfg_mode_wr = 1'b1; cfg_mode_poll = val;
      tick();
      cfg_mode_wr = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R12", "unexpected done", 1, 0);
         end else begin
            automatic bit e = exp_q.pop_front();
            check(fail == e, "R8", "fail flag", fail, e);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check({done, fail, irq, busy, stat_req, poll_mode} == 6'b0, "R1", "reset outputs",
            {done, fail, irq, busy, stat_req, poll_mode}, 0);

      // pin mode: ready held high must not complete
      start_op(2'd0);
      for (int i = 0; i < 6; i++) begin
         check(done == 1'b0 && stat_req == 1'b0, "R3", "no completion on steady high", done, 0);
         tick();
      end
      rb_in = 1'b0;
      for (int i = 0; i < 5; i++) begin
         tick();
         check(done == 1'b0 && busy == 1'b1, "R3", "busy on steady low", done, 0);
      end
      rb_in = 1'b1;
      tick(); tick();
      check(done == 1'b0, "R2", "done too early", done, 0);
      exp_q.push_back(1'b0);
      tick();
      check(done == 1'b1, "R2", "done after sync", done, 1);
      check(busy == 1'b0, "R2", "idle after done", busy, 0);
      tick();
      check(done == 1'b0, "R12", "done single pulse", done, 0);
      check(irq == 1'b1, "R10", "irq sticky", irq, 1);
      irq_clr = 1'b1; tick(); irq_clr = 1'b0;
      check(irq == 1'b0, "R10", "irq cleared", irq, 0);

      // switch to polling while idle
      write_mode(1'b1);
      check(poll_mode == 1'b1, "R11", "idle mode write", poll_mode, 1);

      // load
      start_op(2'd0);
      expect_req_after(5, "R4");
      respond(8'h40, 1'b0, "R8");

      // program with a not-ready poll and a fail result
      start_op(2'd1);
      expect_req_after(9, "R5");
      respond(8'h00, 1'b0, "R7");
      expect_req_after(3, "R7");
      for (int i = 0; i < 4; i++) begin
         tick();
         check(stat_req == 1'b1, "R7", "request held", stat_req, 1);
      end
      respond(8'h41, 1'b0, "R8");

      // erase, with a start pulse while busy and a deferred mode write
      start_op(2'd2);
      check(stat_req == 1'b0, "R6", "stat_req early", stat_req, 0);
      op_start = 1'b1; op_kind = 2'd0;
      tick();
      op_start = 1'b0;
      check(stat_req == 1'b0, "R12", "restart ignored", stat_req, 0);
      for (int i = 0; i < 12; i++) begin
         tick();
         check(stat_req == 1'b0, "R6", "stat_req during wait", stat_req, 0);
      end
      tick();
      check(stat_req == 1'b1, "R6", "erase poll on time", stat_req, 1);
      write_mode(1'b0);
      check(poll_mode == 1'b1, "R11", "mode held while busy", poll_mode, 1);
      respond(8'h40, 1'b1, "R8");
      check(irq == 1'b1, "R10", "set wins over clear", irq, 1);
      check(poll_mode == 1'b1, "R11", "mode held at done", poll_mode, 1);
      tick();
      check(poll_mode == 1'b0, "R11", "deferred mode applied", poll_mode, 0);

      // zero counts
      cfg_load_wait = 16'd0; cfg_poll_gap = 16'd0;
      write_mode(1'b1);
      start_op(2'd0);
      expect_req_after(0, "R9");
      respond(8'h00, 1'b0, "R9");
      expect_req_after(0, "R9");
      respond(8'h40, 1'b0, "R9");

      tick();
      check(exp_q.size() == 0, "R12", "all completions seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule